// File: doc/BRIEF.md
# Debug Link Protocol Selector

This block watches the single shared debug data/mode line, which the debug clock samples on every rising edge. From that bit stream it decides whether the serial-wire protocol engine or the JTAG engine owns the link. It reports the chosen protocol on a level output. It also raises a one-cycle reset strobe whenever a selection is committed, so that the protocol logic downstream starts from a clean state.

A selection is accepted only when it is framed correctly. First comes a line reset, which is a long run of high samples. Then comes a 16-bit select word sent least significant bit first. Last comes a second run of high samples that follows the word. Unknown words, short runs and interrupted trailers are all discarded, and the current protocol is kept. After power-on reset the block starts in the protocol chosen by a parameter.

Top module: `dbg_link_sel`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mode_o` equals the `INIT_JTAG` parameter (1 = JTAG, 0 = serial wire) and `proto_rst_o` is 0.
- R2: The detector arms after `RUN_LEN` (50) consecutive high samples. 49 high samples are not enough. A run of any greater length, for example 300, still arms it.
- R3: Once armed, the first low sample is bit 0 of the select word. The next 15 samples fill bits 1 to 15 in order. The word 0xE73C selects JTAG.
- R4: The legacy word 0xDEAE also selects JTAG when `LEGACY_EN` is 1.
- R5: The word 0xE79E selects the serial-wire protocol (`mode_o` = 0).
- R6: Any other word leaves `mode_o` unchanged and produces no strobe. The detector then needs a fresh line reset before it accepts a new word.
- R7: A recognised word is committed on the `RUN_LEN`-th consecutive high sample that comes after its last bit. High bits inside the word itself do not count toward this run. `mode_o` and `proto_rst_o` change at the clock edge that samples that bit.
- R8: A low sample during the trailing run abandons the selection, and `mode_o` is unchanged.
- R9: `proto_rst_o` is high for exactly one cycle on each commit.
- R10: The trailing run of a commit also counts as a line reset, so a second framed word may follow it directly.
- R11: `mode_o` changes only in a cycle in which `proto_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; `line_i` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Shared debug data/mode line |
| mode_o | output | 1 | Active protocol: 1 = JTAG, 0 = serial wire |
| proto_rst_o | output | 1 | One-cycle strobe that resets the protocol logic on commit |

## Verification
The assertions assume that `line_i` is a clean synchronous bit, stable around each rising edge, and that reset is held for at least one full edge before checking starts. The bench meets both conditions. It changes `line_i` only on falling edges and keeps `rst` high for two edges at the start of every scenario. The assertions say nothing about which words are legal. For that reason the bench sweeps every single-bit corruption of the JTAG word and also sends words that are plainly foreign, so the rejection path is exercised from both kinds of input.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

    typedef enum logic {
        LINK_SWD  = 1'b0,
        LINK_JTAG = 1'b1
    } link_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SHIFT,
        ST_TAIL
    } det_state_e;

    typedef struct packed {
        logic  hit;
        link_e target;
    } sel_result_t;

    localparam int unsigned DEF_RUN_LEN    = 50;
    localparam int unsigned DEF_SEL_W      = 16;
    localparam logic [15:0] DEF_SEL_JTAG   = 16'hE73C;
    localparam logic [15:0] DEF_SEL_LEGACY = 16'hDEAE;
    localparam logic [15:0] DEF_SEL_SWD    = 16'hE79E;

    function automatic sel_result_t pick_target(input logic hit_jtag,
                                                input logic hit_legacy,
                                                input logic hit_swd);
        sel_result_t r;
        r.hit    = hit_jtag | hit_legacy | hit_swd;
        r.target = (hit_jtag | hit_legacy) ? LINK_JTAG : LINK_SWD;
        return r;
    endfunction

endpackage

// File: rtl/dbg_link_run.sv
module dbg_link_run #(
    parameter int unsigned RUN_LEN = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic clr_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i || !line_i) begin
            run_q <= '0;
        end else if (run_q != CW'(RUN_LEN)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // The current high sample completes (or extends) a qualifying run
    assign done_o = line_i && (run_q >= CW'(RUN_LEN - 1));

endmodule

// File: rtl/dbg_link_shift.sv
module dbg_link_shift #(
    parameter int unsigned SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             bit_i,
    output logic [SEL_W-1:0] word_o,
    output logic             last_o
);
    localparam int unsigned IW = $clog2(SEL_W);

    logic [SEL_W-1:0] sh_q;
    logic [IW-1:0]    idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (en_i) begin
            sh_q  <= {bit_i, sh_q[SEL_W-1:1]};
            idx_q <= start_i ? IW'(1) : idx_q + 1'b1;
        end
    end

    // Word as it stands once the current bit lands in the top position
    assign word_o = {bit_i, sh_q[SEL_W-1:1]};
    assign last_o = en_i && !start_i && (idx_q == IW'(SEL_W - 1));

endmodule

// File: rtl/dbg_link_fsm.sv
module dbg_link_fsm
    import dbg_link_pkg::*;
#(
    parameter int unsigned      SEL_W      = 16,
    parameter logic [SEL_W-1:0] SEL_JTAG   = DEF_SEL_JTAG,
    parameter logic [SEL_W-1:0] SEL_LEGACY = DEF_SEL_LEGACY,
    parameter logic [SEL_W-1:0] SEL_SWD    = DEF_SEL_SWD,
    parameter bit               LEGACY_EN  = 1'b1,
    parameter bit               INIT_JTAG  = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             run_done_i,
    input  logic [SEL_W-1:0] word_i,
    input  logic             last_i,
    output logic             shift_en_o,
    output logic             shift_start_o,
    output logic             run_clr_o,
    output link_e            mode_o,
    output logic             pulse_o
);
    localparam link_e INIT_MODE = INIT_JTAG ? LINK_JTAG : LINK_SWD;

    det_state_e  state_q, state_d;
    link_e       tgt_q, tgt_d;
    link_e       mode_q;
    logic        pulse_q;
    logic        commit;
    logic        hit_jtag, hit_legacy, hit_swd;
    sel_result_t res;

    assign hit_jtag = (word_i == SEL_JTAG);
    assign hit_swd  = (word_i == SEL_SWD);

    generate
        if (LEGACY_EN) begin : g_legacy
            assign hit_legacy = (word_i == SEL_LEGACY);
        end else begin : g_no_legacy
            assign hit_legacy = 1'b0;
        end
    endgenerate

    assign res = pick_target(hit_jtag, hit_legacy, hit_swd);

    always_comb begin
        state_d       = state_q;
        tgt_d         = tgt_q;
        shift_en_o    = 1'b0;
        shift_start_o = 1'b0;
        run_clr_o     = 1'b0;
        commit        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_done_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!line_i) begin
                    shift_en_o    = 1'b1;
                    shift_start_o = 1'b1;
                    state_d       = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                shift_en_o = 1'b1;
                if (last_i) begin
                    run_clr_o = 1'b1;
                    if (res.hit) begin
                        tgt_d   = res.target;
                        state_d = ST_TAIL;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_TAIL: begin
                if (!line_i) begin
                    state_d = ST_IDLE;
                end else if (run_done_i) begin
                    commit  = 1'b1;
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= INIT_MODE;
            mode_q  <= INIT_MODE;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            pulse_q <= commit;
            if (commit) mode_q <= tgt_q;
        end
    end

    assign mode_o  = mode_q;
    assign pulse_o = pulse_q;

endmodule

// File: rtl/dbg_link_sel.sv
module dbg_link_sel
    import dbg_link_pkg::*;
#(
    parameter int unsigned      RUN_LEN    = DEF_RUN_LEN,
    parameter int unsigned      SEL_W      = DEF_SEL_W,
    parameter logic [SEL_W-1:0] SEL_JTAG   = DEF_SEL_JTAG,
    parameter logic [SEL_W-1:0] SEL_LEGACY = DEF_SEL_LEGACY,
    parameter logic [SEL_W-1:0] SEL_SWD    = DEF_SEL_SWD,
    parameter bit               LEGACY_EN  = 1'b1,
    parameter bit               INIT_JTAG  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic mode_o,
    output logic proto_rst_o
);
    logic             run_done, run_clr;
    logic             sh_en, sh_start, sh_last;
    logic [SEL_W-1:0] sh_word;
    link_e            mode;

    dbg_link_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .clr_i  (run_clr),
        .done_o (run_done)
    );

    dbg_link_shift #(.SEL_W(SEL_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .en_i    (sh_en),
        .start_i (sh_start),
        .bit_i   (line_i),
        .word_o  (sh_word),
        .last_o  (sh_last)
    );

    dbg_link_fsm #(
        .SEL_W      (SEL_W),
        .SEL_JTAG   (SEL_JTAG),
        .SEL_LEGACY (SEL_LEGACY),
        .SEL_SWD    (SEL_SWD),
        .LEGACY_EN  (LEGACY_EN),
        .INIT_JTAG  (INIT_JTAG)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .line_i        (line_i),
        .run_done_i    (run_done),
        .word_i        (sh_word),
        .last_i        (sh_last),
        .shift_en_o    (sh_en),
        .shift_start_o (sh_start),
        .run_clr_o     (run_clr),
        .mode_o        (mode),
        .pulse_o       (proto_rst_o)
    );

    assign mode_o = (mode == LINK_JTAG);

endmodule

// File: rtl/dbg_link_sel_chk.sv
module dbg_link_sel_chk #(
    parameter int unsigned RUN_LEN   = 50,
    parameter bit          INIT_JTAG = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic line_i,
    input logic mode_o,
    input logic proto_rst_o
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);

    // Independent tally of consecutive high samples, saturating
    logic [CW-1:0] highs_q;

    always_ff @(posedge clk) begin
        if (rst || !line_i) begin
            highs_q <= '0;
        end else if (highs_q != CW'(RUN_LEN)) begin
            highs_q <= highs_q + 1'b1;
        end
    end

    // R1: reset leaves the configured protocol and a quiet strobe
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mode_o == INIT_JTAG) && !proto_rst_o);

    // R9: strobe lasts a single cycle
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        proto_rst_o |=> !proto_rst_o);

    // R11: protocol changes only together with the strobe
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_o) |-> proto_rst_o);

    // R7: a commit follows a sampled high bit
    a_r7_after_high: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_rst_o) |-> $past(line_i));

    // R7: a commit is preceded by a full run of high samples
    a_r7_full_run: assert property (@(posedge clk) disable iff (rst)
        proto_rst_o |-> (highs_q == CW'(RUN_LEN)));

endmodule

bind dbg_link_sel dbg_link_sel_chk #(
    .RUN_LEN   (RUN_LEN),
    .INIT_JTAG (INIT_JTAG)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_i      (line_i),
    .mode_o      (mode_o),
    .proto_rst_o (proto_rst_o)
);

// File: tb/dbg_link_sel_test.sv
module dbg_link_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int RUN        = 50;
    localparam logic [15:0] W_JTAG = 16'hE73C;
    localparam logic [15:0] W_LEG  = 16'hDEAE;
    localparam logic [15:0] W_SWD  = 16'hE79E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_i = 1'b0;
    logic mode_o, proto_rst_o;
    logic alt_mode, alt_rst;

    int checks = 0;
    int fails  = 0;
    int pcnt   = 0;
    int dbl    = 0;
    logic prev_p = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_link_sel uut (
        .clk(clk), .rst(rst), .line_i(line_i),
        .mode_o(mode_o), .proto_rst_o(proto_rst_o)
    );

    dbg_link_sel #(.INIT_JTAG(1'b1)) uut_alt (
        .clk(clk), .rst(rst), .line_i(line_i),
        .mode_o(alt_mode), .proto_rst_o(alt_rst)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one bit at a falling edge; return at the next falling edge
    task automatic send(input logic b);
        line_i = b;
        @(negedge clk);
        if (proto_rst_o) pcnt++;
        if (proto_rst_o && prev_p) dbl++;
        prev_p = proto_rst_o;
    endtask

    task automatic send_highs(input int n);
        for (int i = 0; i < n; i++) send(1'b1);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 0; i < 16; i++) send(w[i]);
    endtask

    task automatic frame(input int lead, input logic [15:0] w, input int tail);
        send_highs(lead);
        send_word(w);
        send_highs(tail);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        line_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        pcnt = 0;
        prev_p = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 mode after reset", mode_o, 0);
        check("R1 strobe after reset", proto_rst_o, 0);
        check("R1 alt mode after reset", alt_mode, 1);

        // R3/R7/R9: exact commit timing for JTAG word
        send_highs(RUN);
        send_word(W_JTAG);
        send_highs(RUN - 1);
        check("R7 no commit one short", mode_o, 0);
        check("R7 no strobe one short", pcnt, 0);
        send(1'b1);
        check("R3 JTAG selected", mode_o, 1);
        check("R9 strobe on commit", proto_rst_o, 1);
        send(1'b1);
        check("R9 strobe drops", proto_rst_o, 0);
        check("R9 one strobe counted", pcnt, 1);

        // R10/R5: second word straight after the trailer
        send_word(W_SWD);
        send_highs(RUN);
        check("R5 serial wire selected", mode_o, 0);
        check("R10 back-to-back strobes", pcnt, 2);
        check("R5 alt to serial wire", alt_mode, 0);

        // R4 legacy word
        do_reset();
        frame(RUN, W_LEG, RUN);
        check("R4 legacy selects JTAG", mode_o, 1);

        // R2 short lead run
        do_reset();
        frame(RUN - 1, W_JTAG, RUN);
        check("R2 49 highs do not arm", mode_o, 0);
        check("R2 no strobe on short lead", pcnt, 0);

        // R2 long lead run
        do_reset();
        frame(300, W_LEG, RUN);
        check("R2 long lead arms", mode_o, 1);

        // R6 sweep of single-bit corruptions
        for (int b = 0; b < 16; b++) begin
            do_reset();
            frame(RUN, W_JTAG ^ 16'(16'h1 << b), RUN);
            check($sformatf("R6 flip bit %0d mode", b), mode_o, 0);
            check($sformatf("R6 flip bit %0d strobe", b), pcnt, 0);
        end

        // R6 recovery needs a fresh line reset
        do_reset();
        frame(RUN, 16'h1234, RUN);
        check("R6 foreign word ignored", mode_o, 0);
        send_word(W_JTAG);
        send_highs(RUN);
        check("R6 accepted after new line reset", mode_o, 1);

        // R8 low inside the trailer
        do_reset();
        frame(RUN, W_JTAG, 20);
        send(1'b0);
        send_highs(60);
        check("R8 broken trailer aborts", mode_o, 0);
        check("R11 mode held without strobe", pcnt, 0);
        send_word(W_JTAG);
        send_highs(RUN);
        check("R8 later frame still works", mode_o, 1);

        check("R9 never two strobes in a row", dbl, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule